// File: doc/BRIEF.md
# Tag-Line-Aware Issue Select

This block is the select stage for one group of functional units that share a single result tag line. Each unit has a latch that holds a tag still waiting for its turn on the shared line. The block takes ready requests from the issue queue, with index 0 the oldest. Each request carries a bit that says whether the instruction will produce a register tag. From these it picks which request goes to which unit in the current cycle. The logic is purely combinational.

A unit whose waiting latch is full must not receive a tag producer, because that producer would overwrite the parked tag. An instruction that produces no tag never touches the latch, so it may still use such a unit. The block steers non-producers toward those units first, which keeps the clear units free for producers.

An optional cap limits how many producers the group takes in one cycle. The cap is computed from the number of tags already waiting. Its purpose is to keep the backlog on the shared line at or below a configured depth.

Top module: `wakeup_select`

## Requirements
- R1: When `enable` is low, every bit of `unitGrant` is 0, whatever the other inputs are.
- R2: Grant bit `u*NUM_REQ+i` means that request i goes to unit u. Each unit's slice has at most one bit set. Each request is granted to at most one unit. A grant is given only to a request whose `reqValid` bit is 1.
- R3: Requests are handled strictly from index 0 upward. Each one takes a unit from those not already taken by older requests. A valid request is left ungranted only when no permitted unit is left for it, or when the cap in R7 has been reached.
- R4: A request with `reqMakesTag` = 1 is never granted to a unit whose `unitWaiting` bit is 1.
- R5: A request with `reqMakesTag` = 0 may go to a unit whose `unitWaiting` bit is 1. It takes the lowest-numbered free unit with a waiting tag. If no such unit is free, it takes the lowest-numbered free unit.
- R6: A request with `reqMakesTag` = 1 takes the lowest-numbered free unit whose `unitWaiting` bit is 0.
- R7: With `CAP_EN` = 1, let W be the number of set `unitWaiting` bits. The number of producer grants in a cycle is at most MAX_WAIT+1−W, and 0 when W > MAX_WAIT+1. Producers beyond the cap, taken in age order, are not granted.
- R8: With `CAP_EN` = 0, producer grants are limited only by R3, R4 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| enable | input | 1 | Global issue enable for this cycle |
| reqValid | input | NUM_REQ | Ready requests, bit 0 is the oldest |
| reqMakesTag | input | NUM_REQ | 1 where the request will produce a register tag |
| unitWaiting | input | NUM_UNITS | 1 where the unit's tag latch still holds a waiting tag |
| unitGrant | output | NUM_UNITS*NUM_REQ | Grant matrix, bit u*NUM_REQ+i grants request i to unit u |

## Verification
The assertions check the following on every input combination: the one-hot shape of each unit's grants, that no request goes to two units, that every grant has a valid request behind it, that nothing is granted when enable is low, that no producer lands on a waiting unit, and that the producer cap holds. The order of preference can only be shown by the bench's exhaustive sweep against an independent model. This covers which older request wins, and that non-producers steer toward waiting units while producers take the lowest clear unit. The same sweep shows that the cap blocks exactly the youngest excess producers, and that the uncapped variant grants them.

// File: rtl/wakeup_sel_pkg.sv
package wakeup_sel_pkg;
  localparam int BUDGET_W = 8;

  typedef struct packed {
    logic                grantEn;
    logic [BUDGET_W-1:0] prodBudget;
  } selStrobe_t;
endpackage

// File: rtl/sel_ctrl.sv
module sel_ctrl
  import wakeup_sel_pkg::*;
#(
  parameter int NUM_UNITS = 2,
  parameter int MAX_WAIT  = 1,
  parameter bit CAP_EN    = 1'b1
) (
  input  logic                 enable,
  input  logic [NUM_UNITS-1:0] unitWaiting,
  output selStrobe_t           strobe
);
  localparam int HEADROOM = MAX_WAIT + 1;

  int waitCnt;
  int budget;

  always_comb begin
    waitCnt = 0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      waitCnt = waitCnt + int'(unitWaiting[u]);
    end
    if (CAP_EN) begin
      budget = (waitCnt > HEADROOM) ? 0 : (HEADROOM - waitCnt);
    end else begin
      budget = NUM_UNITS;
    end
    strobe.grantEn    = enable;
    strobe.prodBudget = BUDGET_W'(budget);
  end
endmodule

// File: rtl/sel_path.sv
module sel_path
  import wakeup_sel_pkg::*;
#(
  parameter int NUM_REQ   = 8,
  parameter int NUM_UNITS = 2
) (
  input  logic [NUM_REQ-1:0]           reqValid,
  input  logic [NUM_REQ-1:0]           reqMakesTag,
  input  logic [NUM_UNITS-1:0]         unitWaiting,
  input  selStrobe_t                   strobe,
  output logic [NUM_UNITS*NUM_REQ-1:0] grantFlat
);
  logic [NUM_UNITS-1:0] freeChain [NUM_REQ+1];
  logic [BUDGET_W-1:0]  prodChain [NUM_REQ+1];

  assign freeChain[0] = {NUM_UNITS{1'b1}};
  assign prodChain[0] = '0;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
    logic [NUM_UNITS-1:0] waitFree;
    logic [NUM_UNITS-1:0] clearFree;
    logic [NUM_UNITS-1:0] cand;
    logic [NUM_UNITS-1:0] pick;
    logic                 allowed;

    assign waitFree  = freeChain[i] & unitWaiting;
    assign clearFree = freeChain[i] & ~unitWaiting;
    assign cand      = reqMakesTag[i] ? clearFree
                     : ((|waitFree) ? waitFree : freeChain[i]);
    assign allowed   = strobe.grantEn & reqValid[i] &
                       (~reqMakesTag[i] | (prodChain[i] < strobe.prodBudget));
    assign pick      = allowed ? (cand & (~cand + NUM_UNITS'(1))) : '0;

    assign freeChain[i+1] = freeChain[i] & ~pick;
    assign prodChain[i+1] = prodChain[i] + BUDGET_W'(reqMakesTag[i] & (|pick));

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      assign grantFlat[u*NUM_REQ+i] = pick[u];
    end
  end
endmodule

// File: rtl/wakeup_select.sv
module wakeup_select
  import wakeup_sel_pkg::*;
#(
  parameter int NUM_REQ   = 8,
  parameter int NUM_UNITS = 2,
  parameter int MAX_WAIT  = 1,
  parameter bit CAP_EN    = 1'b1
) (
  input  logic                         enable,
  input  logic [NUM_REQ-1:0]           reqValid,
  input  logic [NUM_REQ-1:0]           reqMakesTag,
  input  logic [NUM_UNITS-1:0]         unitWaiting,
  output logic [NUM_UNITS*NUM_REQ-1:0] unitGrant
);
  selStrobe_t strobe;

  sel_ctrl #(
    .NUM_UNITS(NUM_UNITS),
    .MAX_WAIT (MAX_WAIT),
    .CAP_EN   (CAP_EN)
  ) u_ctrl (
    .enable     (enable),
    .unitWaiting(unitWaiting),
    .strobe     (strobe)
  );

  sel_path #(
    .NUM_REQ  (NUM_REQ),
    .NUM_UNITS(NUM_UNITS)
  ) u_path (
    .reqValid   (reqValid),
    .reqMakesTag(reqMakesTag),
    .unitWaiting(unitWaiting),
    .strobe     (strobe),
    .grantFlat  (unitGrant)
  );
endmodule

// File: rtl/wakeup_select_check.sv
module wakeup_select_check #(
  parameter int NUM_REQ   = 8,
  parameter int NUM_UNITS = 2,
  parameter int MAX_WAIT  = 1,
  parameter bit CAP_EN    = 1'b1
) (
  input logic                         enable,
  input logic [NUM_REQ-1:0]           reqValid,
  input logic [NUM_REQ-1:0]           reqMakesTag,
  input logic [NUM_UNITS-1:0]         unitWaiting,
  input logic [NUM_UNITS*NUM_REQ-1:0] unitGrant
);
  always_comb begin
    automatic int nWait = 0;
    automatic int nProd = 0;
    automatic int cap;
    automatic logic [NUM_REQ-1:0] seen = '0;

    AST_OFF_NO_GRANT: assert (enable || unitGrant == '0); // R1
    for (int u = 0; u < NUM_UNITS; u++) begin
      nWait = nWait + int'(unitWaiting[u]);
      AST_UNIT_ONEHOT: assert ($onehot0(unitGrant[u*NUM_REQ +: NUM_REQ])); // R2
      AST_REQ_UNIQUE: assert ((seen & unitGrant[u*NUM_REQ +: NUM_REQ]) == '0); // R2
      AST_GRANT_VALID: assert ((unitGrant[u*NUM_REQ +: NUM_REQ] & ~reqValid) == '0); // R2
      seen = seen | unitGrant[u*NUM_REQ +: NUM_REQ];
      if (unitWaiting[u]) begin
        AST_NO_TAG_OVERWRITE: assert ((unitGrant[u*NUM_REQ +: NUM_REQ] & reqMakesTag) == '0); // R4
      end
    end
    for (int i = 0; i < NUM_REQ; i++) begin
      nProd = nProd + int'(seen[i] & reqMakesTag[i]);
    end
    cap = (nWait > MAX_WAIT + 1) ? 0 : (MAX_WAIT + 1 - nWait);
    if (CAP_EN) begin
      AST_PROD_CAP: assert (nProd <= cap); // R7
    end
  end
endmodule

bind wakeup_select wakeup_select_check #(
  .NUM_REQ  (NUM_REQ),
  .NUM_UNITS(NUM_UNITS),
  .MAX_WAIT (MAX_WAIT),
  .CAP_EN   (CAP_EN)
) u_check (
  .enable     (enable),
  .reqValid   (reqValid),
  .reqMakesTag(reqMakesTag),
  .unitWaiting(unitWaiting),
  .unitGrant  (unitGrant)
);

// File: tb/wakeup_select_test.sv
`timescale 1ns/1ps
module wakeup_select_test;
  localparam int NR = 4;
  localparam int NU = 3;
  localparam int MW = 1;
  localparam int GW = NR * NU;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          enable;
  logic [NR-1:0] reqValid;
  logic [NR-1:0] reqMakesTag;
  logic [NU-1:0] unitWaiting;
  logic [GW-1:0] grantCap;
  logic [GW-1:0] grantFree;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 1'b0;

  wakeup_select #(.NUM_REQ(NR), .NUM_UNITS(NU), .MAX_WAIT(MW), .CAP_EN(1'b1)) uut (
    .enable(enable), .reqValid(reqValid), .reqMakesTag(reqMakesTag),
    .unitWaiting(unitWaiting), .unitGrant(grantCap));

  wakeup_select #(.NUM_REQ(NR), .NUM_UNITS(NU), .MAX_WAIT(MW), .CAP_EN(1'b0)) uutNoCap (
    .enable(enable), .reqValid(reqValid), .reqMakesTag(reqMakesTag),
    .unitWaiting(unitWaiting), .unitGrant(grantFree));

  function automatic logic [GW-1:0] model(input bit en, input logic [NR-1:0] rq,
      input logic [NR-1:0] mk, input logic [NU-1:0] wt, input bit capOn);
    logic [GW-1:0] g = '0;
    bit used [NU];
    int nW = 0, cap, given = 0, slot;
    for (int u = 0; u < NU; u++) begin used[u] = 0; nW += int'(wt[u]); end
    cap = capOn ? ((nW > MW + 1) ? 0 : MW + 1 - nW) : 1000;
    if (!en) return g;
    for (int i = 0; i < NR; i++) begin
      slot = -1;
      if (rq[i] && mk[i] && given < cap) begin
        for (int u = NU - 1; u >= 0; u--) if (!used[u] && !wt[u]) slot = u;
        if (slot >= 0) given++;
      end else if (rq[i] && !mk[i]) begin
        for (int u = NU - 1; u >= 0; u--) if (!used[u]) slot = u;
        for (int u = NU - 1; u >= 0; u--) if (!used[u] && wt[u]) slot = u;
      end
      if (slot >= 0) begin used[slot] = 1; g[slot*NR+i] = 1'b1; end
    end
    return g;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [GW-1:0] act,
                       input logic [GW-1:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s en=%b req=%b mk=%b wait=%b actual=%h expected=%h",
               tag, enable, reqValid, reqMakesTag, unitWaiting, act, exp);
    end
  endtask

  initial begin
    for (int cyc = 0; cyc < 50000; cyc++) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    enable = 0; reqValid = '0; reqMakesTag = '0; unitWaiting = '0;
    @(negedge clk);
    check(grantCap == '0 && grantFree == '0, "R2 idle inputs", grantCap, '0);
    for (int combo = 0; combo < 4096; combo++) begin
      @(posedge clk);
      enable      = combo[11];
      reqValid    = combo[3:0];
      reqMakesTag = combo[7:4];
      unitWaiting = combo[10:8];
      @(negedge clk);
      begin
        logic [GW-1:0] expCap, expFree, seen;
        int nW, nP, cap;
        bit shapeOk, overOk;
        expCap  = model(enable, reqValid, reqMakesTag, unitWaiting, 1'b1);
        expFree = model(enable, reqValid, reqMakesTag, unitWaiting, 1'b0);
        if (!enable)
          check(grantCap == '0 && grantFree == '0, "R1 enable low", grantCap, '0);
        else
          check(grantCap == expCap, "R3 R5 R6 order", grantCap, expCap);
        check(grantFree == expFree, "R8 uncapped", grantFree, expFree);
        shapeOk = 1; overOk = 1; seen = '0; nW = 0; nP = 0;
        for (int u = 0; u < NU; u++) begin
          if ($countones(grantCap[u*NR +: NR]) > 1) shapeOk = 0;
          if ((seen[NR-1:0] & grantCap[u*NR +: NR]) != '0) shapeOk = 0;
          if ((grantCap[u*NR +: NR] & ~reqValid) != '0) shapeOk = 0;
          seen[NR-1:0] = seen[NR-1:0] | grantCap[u*NR +: NR];
          if (unitWaiting[u] && (grantCap[u*NR +: NR] & reqMakesTag) != '0) overOk = 0;
          nW += int'(unitWaiting[u]);
        end
        for (int i = 0; i < NR; i++) nP += int'(seen[i] & reqMakesTag[i]);
        cap = (nW > MW + 1) ? 0 : MW + 1 - nW;
        check(shapeOk, "R2 shape", grantCap, expCap);
        check(overOk, "R4 no overwrite", grantCap, expCap);
        check(nP <= cap, "R7 producer cap", GW'(nP), GW'(cap));
      end
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule